// File: doc/BRIEF.md
# Even-Ratio Serial Clock Generator

This block derives a serial-interface clock from the system clock. Software supplies a 16-bit ratio. The block clears the least significant bit of that ratio so the two halves of every serial clock period always last the same number of system clocks. A ratio of zero (or one, which becomes zero once the bit is cleared) selects the slowest rate, 65536 system clocks per serial period. A ratio of two gives the fastest rate, one system clock per half-period.

A `run` input gates generation. While `run` is low the phase counter is held at zero and the clock output rests at the idle level chosen by `cpol`. When `run` rises, the first edge arrives one half-period later. Every edge comes with a one-cycle toggle strobe. The edge is also classed as leading (leaving idle) or trailing (returning to idle). From that class and `cpha` the block produces the sample and shift strobes that a shift engine needs.

Top module: `sclk_divider`

## Requirements
- R1: While `run` is high, `sclk_tgl` pulses once every H system clocks, where H = (ratio with bit 0 cleared)/2. `sclk` changes level in exactly the cycles where `sclk_tgl` is high, so one serial period lasts 2H = the even ratio.
- R2: Bit 0 of `div_val` has no effect: an odd ratio behaves exactly like the even ratio just below it.
- R3: A `div_val` of 0 or 1 gives H = 32768, which divides the system clock by 65536.
- R4: A `div_val` of 2 (or 3) gives H = 1: `sclk` toggles on every system clock while running.
- R5: One clock after `run` is sampled low, `sclk` equals the `cpol` level, all strobes are low, and the phase count is cleared.
- R6: After `run` rises, the first `sclk` edge appears on the H-th rising system clock edge at which `run` is sampled high. Later edges follow every H clocks.
- R7: `lead_stb` pulses with an edge that moves `sclk` away from the `cpol` level. `trail_stb` pulses with an edge that returns it to that level. The two never pulse together, and `sclk_tgl` is their OR.
- R8: With `cpha` = 0, `sample_stb` equals `lead_stb` and `shift_stb` equals `trail_stb`. With `cpha` = 1 the two are swapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run | input | 1 | Enables clock generation; low holds the idle state |
| div_val | input | 16 | Ratio from software; bit 0 is ignored, 0 means 65536 |
| cpol | input | 1 | Idle level of `sclk` |
| cpha | input | 1 | Selects which edge samples and which shifts |
| sclk | output | 1 | Generated serial clock |
| sclk_tgl | output | 1 | One-cycle pulse in the cycle `sclk` has just changed |
| lead_stb | output | 1 | Pulse for an edge leaving the idle level |
| trail_stb | output | 1 | Pulse for an edge returning to the idle level |
| sample_stb | output | 1 | Pulse on the edge where the shift engine samples |
| shift_stb | output | 1 | Pulse on the edge where the shift engine launches data |

## Verification
The divider is run with even ratios 2, 4 and 10, and with odd ratios 3 and 11. Comparing each odd ratio with its even neighbour shows whether bit 0 is really ignored. Ratios 0 and 1 are checked at the 32768-clock half-period, which tells a correct 65536 wrap apart from a divide-by-zero or divide-by-one. Each idle polarity is tried with each phase setting, so a swapped leading/trailing class or a swapped sample/shift mapping shows up. Dropping `run` in the middle of a half-period and restarting shows whether the phase really restarts and the clock returns to idle.

// File: rtl/sclk_pkg.sv
// Package: shared types for the serial clock generator.
// Assumes nothing beyond IEEE 1800-2017 packages.
package sclk_pkg;

    // Class of an sclk edge relative to the idle level.
    typedef enum logic {
        EDGE_LEAD  = 1'b0,
        EDGE_TRAIL = 1'b1
    } edge_kind_e;

    // Pick the edge class on which the shift engine samples, given the phase bit.
    function automatic edge_kind_e sample_kind(input logic phase);
        return phase ? EDGE_TRAIL : EDGE_LEAD;
    endfunction

endpackage

// File: rtl/sclk_ratio_decode.sv
// Module: sclk_ratio_decode
// Turns the software ratio into a half-period length in system clocks.
// Bit 0 is discarded. A zero result maps to the largest half-period,
// 2**(DIV_W-1). Purely combinational; assumes DIV_W >= 2.
module sclk_ratio_decode #(
    parameter int DIV_W = 16
) (
    input  logic [DIV_W-1:0] div_val,
    output logic [DIV_W-1:0] half_len
);
    localparam logic [DIV_W-1:0] MAX_HALF = DIV_W'(1) << (DIV_W - 1);

    logic [DIV_W-2:0] even_half;

    // Drop bit 0 and halve; substitute the maximum when the result is zero.
    always_comb begin
        even_half = div_val[DIV_W-1:1];
        if (even_half == '0) begin
            half_len = MAX_HALF;
        end else begin
            half_len = {1'b0, even_half};
        end
    end
endmodule

// File: rtl/sclk_phase_counter.sv
// Module: sclk_phase_counter
// Counts system clocks within one sclk half-period and flags the last one.
// Held at zero while run is low. Assumes half_len >= 1.
module sclk_phase_counter #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half_len,
    output logic             hit
);
    logic [DIV_W-1:0] count_q;

    // Terminal count: this cycle's edge ends the current half-period.
    assign hit = run && (count_q == half_len - DIV_W'(1));

    // Advance the count, wrap at the terminal value, clear when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || hit) begin
            count_q <= '0;
        end else begin
            count_q <= count_q + DIV_W'(1);
        end
    end
endmodule

// File: rtl/sclk_edge_gen.sv
// Module: sclk_edge_gen
// Owns the sclk level and the registered edge strobes. On each hit it
// flips sclk and classes the edge from the level it leaves. Idle forces
// the cpol level. All outputs are registered.
module sclk_edge_gen
    import sclk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic hit,
    input  logic cpol,
    input  logic cpha,
    output logic sclk,
    output logic lead_stb,
    output logic trail_stb,
    output logic sample_stb,
    output logic shift_stb
);
    edge_kind_e kind;
    edge_kind_e samp_kind;

    // Class of the edge about to happen, from the level it leaves.
    assign kind      = (sclk == cpol) ? EDGE_LEAD : EDGE_TRAIL;
    assign samp_kind = sample_kind(cpha);

    // Clock level register: rest at cpol when idle, flip on each hit.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            sclk <= cpol;
        end else if (hit) begin
            sclk <= ~sclk;
        end
    end

    // Edge strobes, registered so they line up with the new sclk level.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || !hit) begin
            lead_stb   <= 1'b0;
            trail_stb  <= 1'b0;
            sample_stb <= 1'b0;
            shift_stb  <= 1'b0;
        end else begin
            lead_stb   <= (kind == EDGE_LEAD);
            trail_stb  <= (kind == EDGE_TRAIL);
            sample_stb <= (kind == samp_kind);
            shift_stb  <= (kind != samp_kind);
        end
    end
endmodule

// File: rtl/sclk_divider.sv
// Module: sclk_divider (top)
// Even-ratio serial clock generator. The ratio is decoded into a half-period
// length, a counter marks half-period ends, and the edge generator drives
// sclk and the strobes. Assumes div_val is steady while run is high.
module sclk_divider #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div_val,
    input  logic             cpol,
    input  logic             cpha,
    output logic             sclk,
    output logic             sclk_tgl,
    output logic             lead_stb,
    output logic             trail_stb,
    output logic             sample_stb,
    output logic             shift_stb
);
    logic [DIV_W-1:0] half_len;
    logic             hit;

    sclk_ratio_decode #(.DIV_W(DIV_W)) dec_i (
        .div_val (div_val),
        .half_len(half_len)
    );

    sclk_phase_counter #(.DIV_W(DIV_W)) cnt_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .half_len(half_len),
        .hit     (hit)
    );

    sclk_edge_gen edge_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .hit       (hit),
        .cpol      (cpol),
        .cpha      (cpha),
        .sclk      (sclk),
        .lead_stb  (lead_stb),
        .trail_stb (trail_stb),
        .sample_stb(sample_stb),
        .shift_stb (shift_stb)
    );

    // Combined toggle strobe: any classified edge.
    assign sclk_tgl = lead_stb | trail_stb;
endmodule

// File: rtl/sclk_divider_chk.sv
// Module: sclk_divider_chk
// Temporal checks on the generator's ports, bound into every sclk_divider.
module sclk_divider_chk (
    input logic clk,
    input logic rst_n,
    input logic run,
    input logic cpol,
    input logic cpha,
    input logic sclk,
    input logic sclk_tgl,
    input logic lead_stb,
    input logic trail_stb,
    input logic sample_stb,
    input logic shift_stb
);
    // R5: idle forces the cpol level and silences strobes one clock later.
    a_r5_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (sclk == $past(cpol)) && !sclk_tgl && !sample_stb && !shift_stb);

    // R1: a toggle strobe marks a real level change of sclk.
    a_r1_toggle_moves: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_tgl |-> sclk != $past(sclk));

    // R1: without a strobe, sclk holds (while running).
    a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && !sclk_tgl) |-> $stable(sclk));

    // R7: leading and trailing strobes are exclusive.
    a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({lead_stb, trail_stb}));

    // R7: a leading edge leaves the idle level.
    a_r7_lead_away: assert property (@(posedge clk) disable iff (!rst_n)
        (lead_stb && $stable(cpol)) |-> sclk != cpol);

    // R8: sample strobe follows the edge class chosen by cpha.
    a_r8_sample_map: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_stb && $stable(cpha)) |-> (cpha ? trail_stb : lead_stb));

    // R8: sample and shift never coincide.
    a_r8_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(sample_stb && shift_stb));
endmodule

bind sclk_divider sclk_divider_chk chk_i (.*);

// File: tb/sclk_divider_tb_top.sv
// Directed bench for sclk_divider: one task per scenario, each self-checking.
module sclk_divider_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic [15:0] div_val = 16'd2;
    logic        cpol = 1'b0;
    logic        cpha = 1'b0;
    logic        sclk, sclk_tgl, lead_stb, trail_stb, sample_stb, shift_stb;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10ns clk = ~clk;

    sclk_divider dut_i (
        .clk(clk), .rst_n(rst_n), .run(run), .div_val(div_val),
        .cpol(cpol), .cpha(cpha), .sclk(sclk), .sclk_tgl(sclk_tgl),
        .lead_stb(lead_stb), .trail_stb(trail_stb),
        .sample_stb(sample_stb), .shift_stb(shift_stb)
    );

    // Record one check result.
    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Put the block in idle with the given settings and check R5.
    task automatic go_idle(input logic pol, input logic pha, input logic [15:0] dv);
        @(negedge clk);
        run = 1'b0; cpol = pol; cpha = pha; div_val = dv;
        @(negedge clk);
        check("R5", "idle sclk", int'(sclk), int'(pol));
        check("R5", "idle strobes",
              int'({sclk_tgl, lead_stb, trail_stb, sample_stb, shift_stb}), 0);
    endtask

    // Run for ncyc clocks and compare all outputs with the model for half-period h.
    task automatic run_pattern(input string req, input logic pol, input logic pha,
                               input logic [15:0] dv, input int h, input int ncyc);
        int bad = 0;
        int edges = 0;
        go_idle(pol, pha, dv);
        run = 1'b1;
        for (int n = 1; n <= ncyc; n++) begin
            logic e_tgl, e_sclk, e_lead, e_trail, e_samp, e_shift;
            @(negedge clk);
            e_tgl   = (n % h) == 0;
            e_sclk  = pol ^ logic'((n / h) & 1);
            e_lead  = e_tgl && (((n / h) & 1) == 1);
            e_trail = e_tgl && !e_lead;
            e_samp  = pha ? e_trail : e_lead;
            e_shift = pha ? e_lead : e_trail;
            if (sclk_tgl) edges++;
            if ({sclk, sclk_tgl, lead_stb, trail_stb, sample_stb, shift_stb} !=
                {e_sclk, e_tgl, e_lead, e_trail, e_samp, e_shift}) begin
                if (bad < 3)
                    $display("FAIL %s cycle %0d outputs: actual %b expected %b", req, n,
                             {sclk, sclk_tgl, lead_stb, trail_stb, sample_stb, shift_stb},
                             {e_sclk, e_tgl, e_lead, e_trail, e_samp, e_shift});
                bad++;
            end
        end
        checks++;
        if (bad != 0) errors++;
        check(req, "edge count", edges, ncyc / h);
        @(negedge clk);
        run = 1'b0;
    endtask

    // R5/R6: drop run mid half-period, then confirm a fresh phase on restart.
    task automatic test_stop_restart();
        go_idle(1'b0, 1'b0, 16'd6);
        run = 1'b1;
        repeat (4) @(negedge clk);
        check("R6", "sclk after first edge", int'(sclk), 1);
        run = 1'b0;
        @(negedge clk);
        check("R5", "sclk back at idle", int'(sclk), 0);
        check("R5", "no strobe on stop", int'(sclk_tgl), 0);
        run_pattern("R6", 1'b0, 1'b0, 16'd6, 3, 20);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R5", "reset sclk", int'(sclk), 0);
        check("R5", "reset strobes", int'({sclk_tgl, sample_stb, shift_stb}), 0);
        rst_n = 1'b1;
        run_pattern("R4", 1'b0, 1'b0, 16'd2, 1, 12);
        run_pattern("R2", 1'b0, 1'b1, 16'd3, 1, 12);
        run_pattern("R1", 1'b0, 1'b0, 16'd4, 2, 24);
        run_pattern("R1", 1'b1, 1'b0, 16'd10, 5, 60);
        run_pattern("R2", 1'b1, 1'b1, 16'd11, 5, 60);
        run_pattern("R8", 1'b0, 1'b1, 16'd8, 4, 40);
        run_pattern("R7", 1'b1, 1'b0, 16'd6, 3, 36);
        test_stop_restart();
        run_pattern("R3", 1'b0, 1'b0, 16'd0, 32768, 66000);
        run_pattern("R3", 1'b1, 1'b1, 16'd1, 32768, 33000);
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (180000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule